// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Counter

This block measures how fast a clock runs. It counts the cycles of that clock over a window timed by a slow reference clock. The measured clock (`clk`) may come from an on-chip RC oscillator with a nominal rate of about 2 MHz, or from an external clock input. The reference clock (`ref_clk`) is slow and accurate. Software raises `en` and waits for `ready`. It then reads `count` and computes the measured frequency as count divided by the window length.

The window opens on the first rising reference edge that follows the synchronized enable. It closes on the sixteenth falling reference edge after that, so it spans fifteen and a half reference periods. The window is built in the reference domain as a level gate and crosses into the measured domain through a two-flop synchronizer. The counter runs there. The ready flag returns to the reference domain through another two-flop synchronizer, which lets the window logic settle in its finished state. Dropping `en` clears the result. Raising `en` again starts a fresh measurement.

Top module: `clk_rate_meter`

## Requirements
- R1: After a synchronous reset, `count` reads 0 and `ready` reads 0.
- R2: While `en` is low, `count` stays 0 and `ready` stays 0 on every `clk` edge.
- R3: After `en` rises, `count` stays 0 until the enable has passed two reference-domain flops and a following rising reference edge has opened the window.
- R4: The window closes on the sixteenth falling `ref_clk` edge after it opens. The final `count` equals the number of `clk` cycles in those 15.5 reference periods, within two cycles of synchronizer skew.
- R5: `ready` rises on the `clk` edge after the synchronized gate is seen low once counting has started. `count` stops incrementing at that point.
- R6: While `ready` and `en` are both high, `ready` stays high and `count` does not change.
- R7: `count` never wraps. It goes up by at most one per `clk` cycle and saturates at 2^CNT_W-1 (65535 with the default width of 16).
- R8: On the first `clk` edge that samples `en` low, `count` returns to 0 and `ready` clears. A later rising `en` starts a new measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measured clock; the counter and `ready` are clocked by it |
| ref_clk | input | 1 | Slow reference clock that times the window |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| en | input | 1 | Measurement enable (oscillator-on) |
| count | output | CNT_W | Measured-clock cycles counted in the window |
| ready | output | 1 | High when `count` holds a finished measurement |

## Verification
The assertions check the following on every measured-clock cycle:
- the cleared state after reset and while disabled;
- that `count` only moves up, in steps of at most one;
- that the result is frozen while `ready` is high.

Other behaviour needs a full run and comes only from the bench scenarios:
- where the window opens and closes on reference edges;
- a count that matches the period ratio for several reference periods;
- saturation under a very long window;
- a new measurement after re-enabling.

The bench model tracks the crossing latency cycle by cycle and compares both outputs on every cycle.

// File: rtl/clk_rate_meter_pkg.sv
package clk_rate_meter_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE    = 2'd0,
    WIN_OPEN    = 2'd1,
    WIN_CLOSING = 2'd2,
    WIN_DONE    = 2'd3
  } win_state_t;
endpackage

// File: rtl/crm_sync.sv
module crm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/crm_ref_window.sv
module crm_ref_window
  import clk_rate_meter_pkg::*;
#(
  parameter int REF_EDGES = 16
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic en_s,
  input  logic rdy_s,
  output logic gate
);
  localparam int EW = $clog2(REF_EDGES + 1);
  localparam logic [EW-1:0] LAST = EW'(REF_EDGES - 1);

  win_state_t      state;
  logic [EW-1:0]   falls;
  logic            closed;

  // Window open/close sequencing on rising reference edges
  always_ff @(posedge ref_clk) begin
    if (rst || !en_s) begin
      state <= WIN_IDLE;
    end else begin
      case (state)
        WIN_IDLE:    state <= WIN_OPEN;
        WIN_OPEN:    if (closed) state <= WIN_CLOSING;
        WIN_CLOSING: if (rdy_s) state <= WIN_DONE;
        default:     state <= WIN_DONE;
      endcase
    end
  end

  // Falling-edge tally; the final falling edge shuts the gate
  always_ff @(negedge ref_clk) begin
    if (rst || state != WIN_OPEN) begin
      falls  <= '0;
      closed <= 1'b0;
    end else if (!closed) begin
      falls <= falls + 1'b1;
      if (falls == LAST) closed <= 1'b1;
    end
  end

  // Each input changes on a different edge, so the gate never glitches
  assign gate = (state == WIN_OPEN) && !closed;
endmodule

// File: rtl/crm_fast_count.sv
module crm_fast_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             gate_s,
  output logic [CNT_W-1:0] count,
  output logic             ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic seen;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      count <= '0;
      ready <= 1'b0;
      seen  <= 1'b0;
    end else if (!ready) begin
      if (gate_s) begin
        seen <= 1'b1;
        if (count != CNT_MAX) count <= count + 1'b1;
      end else if (seen) begin
        ready <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_rate_meter.sv
module clk_rate_meter #(
  parameter int CNT_W       = 16,
  parameter int REF_EDGES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] count,
  output logic             ready
);
  logic en_ref;
  logic rdy_ref;
  logic gate_ref;
  logic gate_fast;

  crm_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk(ref_clk), .rst(rst), .d(en), .q(en_ref)
  );

  crm_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(ref_clk), .rst(rst), .d(ready), .q(rdy_ref)
  );

  crm_ref_window #(.REF_EDGES(REF_EDGES)) u_window (
    .ref_clk(ref_clk), .rst(rst), .en_s(en_ref), .rdy_s(rdy_ref), .gate(gate_ref)
  );

  crm_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst(rst), .d(gate_ref), .q(gate_fast)
  );

  crm_fast_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .en(en), .gate_s(gate_fast),
    .count(count), .ready(ready)
  );
endmodule

// File: rtl/clk_rate_meter_chk.sv
module clk_rate_meter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [CNT_W-1:0] count,
  input logic             ready
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (count == '0 && !ready));

  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (count == '0 && !ready));

  a_r6_result_frozen: assert property (@(posedge clk) disable iff (rst)
    (ready && en) |=> (ready && $stable(count)));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    en |=> (count >= $past(count)));

  a_r7_unit_step: assert property (@(posedge clk) disable iff (rst)
    en |=> ({1'b0, count} <= {1'b0, $past(count)} + 1'b1));
endmodule

bind clk_rate_meter clk_rate_meter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .count(count), .ready(ready)
);

// File: tb/clk_rate_meter_test.sv
module clk_rate_meter_test;
  localparam int CW = 16;
  localparam int WATCHDOG = 190000;

  logic          clk = 1'b0;
  logic          ref_clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [CW-1:0] count;
  logic          ready;

  int ref_half = 50;     // even, so reference edges stay at odd ns
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit live = 1'b0;

  clk_rate_meter uut (
    .clk(clk), .ref_clk(ref_clk), .rst(rst), .en(en),
    .count(count), .ready(ready)
  );

  always #4 clk = ~clk;   // 125 MHz, edges at even ns
  initial begin
    #3;
    forever #(ref_half) ref_clk = ~ref_clk;
  end

  // ---------------- behavioural reference model ----------------
  int  m_state = 0;        // 0 idle, 1 window open, 2 wait ready, 3 finished
  int  m_falls = 0;
  bit  m_closed = 0;
  bit  m_gate = 0;
  bit  en_q[$] = '{0, 0};
  bit  rd_q[$] = '{0, 0};
  bit  gt_q[$] = '{0, 0};
  int  m_cnt = 0;
  bit  m_rdy = 0;
  bit  m_seen = 0;

  always @(posedge ref_clk) begin
    bit en_old, rd_old;
    if (rst) begin
      en_q = '{0, 0}; rd_q = '{0, 0}; m_state = 0;
    end else begin
      en_q.push_back(en);    en_old = en_q.pop_front();
      rd_q.push_back(m_rdy); rd_old = rd_q.pop_front();
      if (!en_old)                    m_state = 0;
      else if (m_state == 0)          m_state = 1;
      else if (m_state == 1 && m_closed) m_state = 2;
      else if (m_state == 2 && rd_old)   m_state = 3;
    end
    m_gate = (m_state == 1) && !m_closed;
  end

  always @(negedge ref_clk) begin
    if (rst || m_state != 1) begin
      m_falls = 0; m_closed = 0;
    end else if (!m_closed) begin
      m_falls++;
      if (m_falls == 16) m_closed = 1;
    end
    m_gate = (m_state == 1) && !m_closed;
  end

  always @(posedge clk) begin
    bit gs;
    cyc++;
    if (rst) begin
      gt_q = '{0, 0}; m_cnt = 0; m_rdy = 0; m_seen = 0;
    end else begin
      gt_q.push_back(m_gate); gs = gt_q.pop_front();
      if (!en) begin
        m_cnt = 0; m_rdy = 0; m_seen = 0;
      end else if (!m_rdy) begin
        if (gs) begin
          m_seen = 1;
          if (m_cnt < 65535) m_cnt++;
        end else if (m_seen) m_rdy = 1;
      end
    end
  end

  // per-cycle comparison against the model (all requirements)
  always @(negedge clk) begin
    if (live) begin
      n_cmp++;
      if (count !== CW'(m_cnt) || ready !== m_rdy) begin
        n_bad++;
        $display("FAIL model R1-model-track: count=%0d ready=%0b expected count=%0d ready=%0b at cycle %0d",
                 count, ready, m_cnt, m_rdy, cyc);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready(input string tag, input int limit);
    int k = 0;
    while (!ready && k < limit) begin
      @(negedge clk); k++;
    end
    check(ready === 1'b1, tag, int'(ready), 1);
  endtask

  task automatic expect_window(input string tag);
    int ideal = (31 * ref_half) / 8;
    int diff = int'(count) - ideal;
    if (diff < 0) diff = -diff;
    check(diff <= 2, tag, int'(count), ideal);
  endtask

  task automatic measure(input int half, input string tag);
    int held;
    en = 1'b0;
    repeat (20) @(negedge clk);
    ref_half = half;
    repeat ((8 * half) / 8 + 20) @(negedge clk);
    en = 1'b1;
    repeat (10) @(negedge clk);
    check(count == 0, "R3 no count before window", int'(count), 0);
    wait_ready({tag, " R5 ready"}, 200 * half);
    expect_window({tag, " R4 window count"});
    held = int'(count);
    repeat (60) @(negedge clk);
    check(ready === 1'b1 && int'(count) == held, "R6 held result", int'(count), held);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (30) @(negedge clk);
    rst = 1'b0;
    live = 1'b1;
    @(negedge clk);
    check(count == 0 && ready == 1'b0, "R1 reset state", int'(count), 0);

    repeat (100) @(negedge clk);
    check(count == 0 && ready == 1'b0, "R2 idle while disabled", int'(count), 0);

    measure(50, "ratio25");
    en = 1'b0;
    @(negedge clk);
    check(count == 0 && ready == 1'b0, "R8 clear on disable", int'(count), 0);

    measure(36, "ratio18 R8 remeasure");
    measure(80, "ratio40");

    // long window forces the counter to its ceiling
    en = 1'b0;
    repeat (40) @(negedge clk);
    ref_half = 17000;
    repeat (30) @(negedge clk);
    en = 1'b1;
    wait_ready("R7 long window ready", 100000);
    check(count == 16'hFFFF, "R7 saturation", int'(count), 65535);
    en = 1'b0;
    @(negedge clk);
    check(count == 0 && ready == 1'b0, "R8 clear after saturation", int'(count), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule